// File: doc/BRIEF.md
# Interrupt Priority Encoder and Acknowledge Decoder

This block sits between seven peripheral interrupt request lines and a processor. The request lines are active low. The block reduces them to a three-bit active-low priority level for the processor's level inputs, and the highest-numbered asserted line sets that level. The encoded level passes through a two-stage register chain before it reaches the outputs, so the processor sees a value that is steady on its own clock even when the requests change asynchronously.

In the other direction, the block watches the processor bus for an interrupt-acknowledge cycle. Such a cycle is marked by the CPU-space function code while the address strobe is active. During that cycle, three low address bits carry the level being serviced. The block then pulls down the one acknowledge line that matches that level, and the interrupting device can start its response. Vector delivery and mask comparison are done elsewhere.

Top module: `irq_ack_glue`

## Requirements
- R1: A synchronous reset (rst high at a rising clock edge) sets `ipl_n` to 3'b111.
- R2: `req_n[i]` low is a request at level i+1. `ipl_n` carries the bitwise inverse of the highest such level, in binary.
- R3: When every `req_n` line is high, `ipl_n` settles to 3'b111, which is level 0.
- R4: A change on `req_n` that is set up before a rising edge appears on `ipl_n` after exactly two rising edges. After the first of those edges, `ipl_n` still holds its previous value.
- R5: When `as_n` is low, `fc` is 3'b111 and `ack_lvl` is a value k from 1 to 7, `iack_n[k-1]` is low and every other `iack_n` bit is high.
- R6: Any `fc` value other than 3'b111 leaves all `iack_n` bits high. This includes the memory codes 3'b001, 3'b010, 3'b101 and 3'b110.
- R7: While `as_n` is high, all `iack_n` bits stay high.
- R8: `ack_lvl` equal to 3'b000 asserts no `iack_n` bit.
- R9: No more than one `iack_n` bit is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the level register chain |
| rst | input | 1 | Synchronous reset, active high |
| req_n | input | 7 | Interrupt requests, active low; bit i is level i+1 |
| fc | input | 3 | Processor function code |
| ack_lvl | input | 3 | Address bits carrying the acknowledged level |
| as_n | input | 1 | Address strobe, active low |
| ipl_n | output | 3 | Encoded priority level, active low |
| iack_n | output | 7 | Acknowledge lines, active low; bit k-1 is level k |

## Verification
The bench uses the default build: seven levels, a three-bit level and two register stages. With that build, all 128 request patterns can be swept, and each pattern is checked both one edge and two edges after it is applied. All 128 combinations of strobe, function code and acknowledge level are also swept exhaustively. This covers every code that must not acknowledge, as well as the zero level.

// File: rtl/irq_glue_pkg.sv
package irq_glue_pkg;

    typedef enum logic [2:0] {
        FC_RSVD0     = 3'b000,
        FC_USR_DATA  = 3'b001,
        FC_USR_PROG  = 3'b010,
        FC_RSVD3     = 3'b011,
        FC_RSVD4     = 3'b100,
        FC_SUP_DATA  = 3'b101,
        FC_SUP_PROG  = 3'b110,
        FC_CPU_SPACE = 3'b111
    } fc_code_t;

    typedef struct packed {
        logic       strobe;
        logic [2:0] fc;
        logic [2:0] lvl;
    } ack_cycle_t;

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N = 7,
    parameter int W = 3
) (
    input  logic [N-1:0] req_n,
    output logic [W-1:0] level
);
    always_comb begin
        level = '0;
        for (int i = 0; i < N; i++) begin
            if (!req_n[i]) level = W'(i + 1);
        end
    end
endmodule

// File: rtl/irq_lvl_sync.sv
module irq_lvl_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage[0] <= '1;
                else     stage[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage[g] <= '1;
                else     stage[g] <= stage[g-1];
            end
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/irq_ack_dec.sv
module irq_ack_dec
    import irq_glue_pkg::*;
#(
    parameter int N = 7,
    parameter int W = 3
) (
    input  ack_cycle_t   cyc,
    output logic [N-1:0] iack_n
);
    logic hit;

    assign hit = cyc.strobe && (cyc.fc == FC_CPU_SPACE);

    always_comb begin
        for (int k = 0; k < N; k++) begin
            iack_n[k] = !(hit && (cyc.lvl == W'(k + 1)));
        end
    end
endmodule

// File: rtl/irq_ack_glue.sv
module irq_ack_glue
    import irq_glue_pkg::*;
#(
    parameter int NUM_LEVELS  = 7,
    parameter int SYNC_STAGES = 2,
    localparam int LVL_W      = $clog2(NUM_LEVELS + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_LEVELS-1:0] req_n,
    input  logic [2:0]            fc,
    input  logic [LVL_W-1:0]      ack_lvl,
    input  logic                  as_n,
    output logic [LVL_W-1:0]      ipl_n,
    output logic [NUM_LEVELS-1:0] iack_n
);
    logic [LVL_W-1:0] enc_lvl;
    ack_cycle_t       cyc;

    irq_prio_enc #(.N(NUM_LEVELS), .W(LVL_W)) i_enc (
        .req_n (req_n),
        .level (enc_lvl)
    );

    irq_lvl_sync #(.W(LVL_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   (~enc_lvl),
        .q   (ipl_n)
    );

    assign cyc.strobe = !as_n;
    assign cyc.fc     = fc;
    assign cyc.lvl    = 3'(ack_lvl);

    irq_ack_dec #(.N(NUM_LEVELS), .W(3)) i_dec (
        .cyc    (cyc),
        .iack_n (iack_n)
    );

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        ($past(&req_n) && $past(&req_n, 2)) |-> (&ipl_n)); // R3
    AST_ACK_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~iack_n)); // R9
    AST_ACK_NEEDS_CPU: assert property (@(posedge clk) disable iff (rst)
        (fc != FC_CPU_SPACE) |-> (&iack_n)); // R6
    AST_ACK_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        as_n |-> (&iack_n)); // R7
    AST_ACK_ZERO_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (ack_lvl == '0) |-> (&iack_n)); // R8
    AST_ACK_MATCH: assert property (@(posedge clk) disable iff (rst)
        (!as_n && fc == FC_CPU_SPACE && ack_lvl != '0)
        |-> ((~iack_n) == (NUM_LEVELS'(1) << (ack_lvl - 1'b1)))); // R5
endmodule

// File: tb/test_irq_ack_glue.sv
module test_irq_ack_glue;
    logic       clk = 1'b0;
    logic       rst;
    logic [6:0] req_n;
    logic [2:0] fc;
    logic [2:0] ack_lvl;
    logic       as_n;
    logic [2:0] ipl_n;
    logic [6:0] iack_n;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    irq_ack_glue i_irq_ack_glue (
        .clk(clk), .rst(rst), .req_n(req_n), .fc(fc),
        .ack_lvl(ack_lvl), .as_n(as_n), .ipl_n(ipl_n), .iack_n(iack_n)
    );

    function automatic logic [2:0] exp_ipl(input logic [6:0] r);
        logic [2:0] l = 3'd0;
        for (int i = 0; i < 7; i++) if (!r[i]) l = 3'(i + 1);
        return ~l;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        logic [2:0] prev;
        rst = 1'b1; req_n = 7'h00; fc = 3'b000; ack_lvl = 3'd0; as_n = 1'b1;
        repeat (3) @(posedge clk);
        #1 check("R1 reset level", {5'd0, ipl_n}, 8'h07);
        @(negedge clk) rst = 1'b0; req_n = 7'h7f;
        repeat (3) @(posedge clk);
        #1 check("R3 idle level", {5'd0, ipl_n}, 8'h07);
        prev = 3'b111;
        for (int p = 0; p < 128; p++) begin
            @(negedge clk) req_n = 7'(p);
            @(posedge clk); #1 check("R4 one-edge hold", {5'd0, ipl_n}, {5'd0, prev});
            @(posedge clk); #1
            if (p == 127) check("R3 no request", {5'd0, ipl_n}, 8'h07);
            else          check("R2 encode", {5'd0, ipl_n}, {5'd0, exp_ipl(7'(p))});
            prev = exp_ipl(7'(p));
        end
        @(negedge clk) req_n = 7'h00;
        repeat (2) @(posedge clk);
        @(negedge clk) rst = 1'b1;
        @(posedge clk); #1 check("R1 mid-run reset", {5'd0, ipl_n}, 8'h07);
        @(negedge clk) rst = 1'b0; req_n = 7'h7f;
        for (int v = 0; v < 128; v++) begin
            logic [6:0] e;
            @(negedge clk);
            as_n = v[6]; fc = v[5:3]; ack_lvl = v[2:0];
            #1;
            e = 7'h7f;
            if (!as_n && fc == 3'b111 && ack_lvl != 3'd0) e[ack_lvl - 1] = 1'b0;
            if (as_n)                  check("R7 strobe idle", {1'b0, iack_n}, {1'b0, e});
            else if (fc != 3'b111)     check("R6 non-cpu code", {1'b0, iack_n}, {1'b0, e});
            else if (ack_lvl == 3'd0)  check("R8 zero level", {1'b0, iack_n}, {1'b0, e});
            else                       check("R5 ack decode", {1'b0, iack_n}, {1'b0, e});
            check("R9 at most one", 8'($countones(~iack_n) <= 1), 8'd1);
        end
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
        end
    end
endmodule